// File: doc/BRIEF.md
# Serial Wire Debug Host Transfer Engine

This block is the probe side of a two-wire debug link. It drives the debug clock and one bidirectional data line, split into an output value, an output enable and an input sample. A controller hands it one command at a time over a valid/ready handshake. A command is either a register transfer, a line reset or the switch from the scan-chain protocol to the two-wire protocol. For a transfer the engine builds the 8-bit request with its own parity and turns the line around around the target's acknowledge. It then moves the 33-bit data phase in the right direction and reports the acknowledge, the read word and a data parity error.

The debug clock comes from the system clock through a divider. The divide value is an input and is changed only while the engine is idle. Each bit slot starts when the debug clock falls, which is when the host changes what it drives. The slot's rising edge is where both sides sample. Between commands the clock rests low and the host drives the line low.

Line reset and the protocol switch run without a target response and raise no response pulse. Completion shows as the return of command ready.

Top module: `swd_host`

## Requirements
- R1: The request is sent as eight slots in this order: 1, AP/DP select, read flag, address bit 2, address bit 3, even parity of those four bits, 0, 1. `cmd_addr_i[0]` is address bit 2 and `cmd_addr_i[1]` is address bit 3. As examples, a DP read of address 0 is 1,0,1,0,0,1,0,1; a DP write of address 4 is 1,0,0,1,0,1,0,1; a DP read of address 4 is 1,0,1,1,0,0,0,1.
- R2: After the request the host releases the line (output enable 0) for one turnaround slot. It keeps the line released for three acknowledge slots, sampled least-significant bit first, and reports that value on `rsp_ack_o`. The acknowledge codes are OK = 3'b001, WAIT = 3'b010 and FAULT = 3'b100.
- R3: A read with OK samples 33 further slots with the line released: 32 data bits LSB first, then the parity bit. `rsp_rdata_o` carries the data. One released turnaround slot follows, after which the host drives again. A read takes 46 slots in total.
- R4: When the received parity bit differs from the even parity of the 32 received data bits, `rsp_perr_o` is 1 even though the acknowledge is OK. Otherwise it is 0, and it is always 0 for writes and non-OK answers.
- R5: A write with OK gives one released turnaround slot. The host then drives 33 slots: the write word LSB first, then its even parity. A write takes 46 slots.
- R6: Any acknowledge other than OK skips the data phase. It is followed by a single released turnaround slot, so the transfer takes 13 slots. `rsp_rdata_o` is 0 and `rsp_perr_o` is 0.
- R7: Operation code 1 (line reset) drives the line high for `LRST_CYCLES` (default 50) clock slots and then returns to idle.
- R8: Operation code 2 (protocol switch) drives `LRST_CYCLES` high slots, then 0xE79E LSB first, then another `LRST_CYCLES` high slots. That is 116 slots at the defaults. Operation code 0 is a transfer.
- R9: The data output and its enable change only when the debug clock falls or while it rests low. They never change while it is high.
- R10: The debug clock rests low when idle. While busy, each half period lasts `clk_div_i`+1 system clock cycles, so successive rising edges are 2·(`clk_div_i`+1) cycles apart.
- R11: `cmd_ready_o` is 1 only while idle. A command is taken on a cycle with valid and ready both high. Every transfer gives exactly one single-cycle `rsp_valid_o` pulse, and the response fields hold until the next command is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_div_i | input | DIV_W | Half-period of the debug clock minus one, in system cycles |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Engine idle, command accepted this cycle if valid |
| cmd_op_i | input | 2 | 0 transfer, 1 line reset, 2 protocol switch (3 acts as line reset) |
| cmd_apndp_i | input | 1 | 1 selects the access port, 0 the debug port |
| cmd_rnw_i | input | 1 | 1 read, 0 write |
| cmd_addr_i | input | 2 | Register address bits 3:2 |
| cmd_wdata_i | input | 32 | Write word |
| rsp_valid_o | output | 1 | One-cycle pulse at the end of a transfer |
| rsp_ack_o | output | 3 | Received acknowledge |
| rsp_rdata_o | output | 32 | Read word, 0 unless an OK read |
| rsp_perr_o | output | 1 | Read data parity mismatch |
| swclk_o | output | 1 | Debug clock |
| swdio_o | output | 1 | Data line output value |
| swdio_oe_o | output | 1 | Data line output enable |
| swdio_i | input | 1 | Data line input sample |

## Verification
The response pulse of one transfer and the acceptance of the next command fall in the same system cycle. Accepting a command clears the acknowledge and read capture registers, which are the registers the pulse is presenting. The bench provokes this on every back-to-back transfer. Its driver presents the next command at the very sample point where it first sees ready return, so the accepting edge closes the pulse cycle. The monitor judges the overlap by comparing the pulsed acknowledge, read word and parity flag against the queued expectation of the earlier transfer, never the newer one. The wire log of the new command must still start with its own request bits.

// File: rtl/swd_pkg.sv
package swd_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    OP_XFER = 2'd0,
    OP_LRST = 2'd1,
    OP_J2S  = 2'd2,
    OP_RSV  = 2'd3
  } swd_op_e;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_REQ,
    PH_TRN1,
    PH_ACK,
    PH_RDATA,
    PH_TRN2,
    PH_WTRN,
    PH_WDATA,
    PH_LRST,
    PH_SEQ,
    PH_LRST2
  } swd_phase_e;

  localparam logic [2:0] ACK_OK    = 3'b001;
  localparam logic [2:0] ACK_WAIT  = 3'b010;
  localparam logic [2:0] ACK_FAULT = 3'b100;

  localparam logic [15:0] SWITCH_WORD = 16'hE79E;

  function automatic logic even_par(input logic [WORD_W-1:0] d);
    return ^d;
  endfunction
endpackage

// File: rtl/swd_clkdiv.sv
module swd_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             swclk_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             clk_q;
  logic             wrap;

  assign wrap    = run_i && (cnt_q >= div_i);
  assign rise_o  = wrap && !clk_q;
  assign fall_o  = wrap && clk_q;
  assign swclk_o = clk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      clk_q <= ~clk_q;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/swd_req_enc.sv
module swd_req_enc (
  input  logic       apndp_i,
  input  logic       rnw_i,
  input  logic [1:0] addr_i,
  output logic [7:0] pkt_o
);
  logic par;

  assign par = apndp_i ^ rnw_i ^ addr_i[0] ^ addr_i[1];

  // index = slot order on the wire
  assign pkt_o = {1'b1, 1'b0, par, addr_i[1], addr_i[0], rnw_i, apndp_i, 1'b1};
endmodule

// File: rtl/swd_rx.sv
module swd_rx
  import swd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              samp_ack_i,
  input  logic              samp_dat_i,
  input  logic              din_i,
  output logic [2:0]        ack_o,
  output logic [WORD_W-1:0] data_o,
  output logic              par_bad_o
);
  logic [2:0]      ack_q;
  logic [WORD_W:0] dat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q <= '0;
      dat_q <= '0;
    end else if (clear_i) begin
      ack_q <= '0;
      dat_q <= '0;
    end else begin
      if (samp_ack_i) ack_q <= {din_i, ack_q[2:1]};
      if (samp_dat_i) dat_q <= {din_i, dat_q[WORD_W:1]};
    end
  end

  assign ack_o     = ack_q;
  assign data_o    = dat_q[WORD_W-1:0];
  assign par_bad_o = dat_q[WORD_W] ^ even_par(dat_q[WORD_W-1:0]);

  assert_ack_data_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(samp_ack_i && samp_dat_i));
endmodule

// File: rtl/swd_host.sv
module swd_host
  import swd_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int LRST_CYCLES = 50
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  clk_div_i,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [1:0]        cmd_op_i,
  input  logic              cmd_apndp_i,
  input  logic              cmd_rnw_i,
  input  logic [1:0]        cmd_addr_i,
  input  logic [WORD_W-1:0] cmd_wdata_i,
  output logic              rsp_valid_o,
  output logic [2:0]        rsp_ack_o,
  output logic [WORD_W-1:0] rsp_rdata_o,
  output logic              rsp_perr_o,
  output logic              swclk_o,
  output logic              swdio_o,
  output logic              swdio_oe_o,
  input  logic              swdio_i
);
  localparam int CNT_MAX = (LRST_CYCLES > WORD_W + 1) ? LRST_CYCLES : WORD_W + 1;
  localparam int CW      = $clog2(CNT_MAX + 1);

  swd_phase_e        phase_q, nxt_phase;
  swd_op_e           op_q;
  logic [CW-1:0]     bit_q, last_bit;
  logic [7:0]        pkt, pkt_q;
  logic [WORD_W-1:0] wdata_q, rx_data;
  logic              wpar_q, rnw_q, rd_ok_q, rsp_valid_q;
  logic              accept, rise, fall, slot_end, ack_ok, par_bad;
  logic [2:0]        rx_ack;
  logic              sdo, soe;

  assign cmd_ready_o = (phase_q == PH_IDLE);
  assign accept      = cmd_valid_i && cmd_ready_o;

  swd_clkdiv #(.DIV_W(DIV_W)) u_clkdiv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (phase_q != PH_IDLE),
    .div_i   (clk_div_i),
    .swclk_o (swclk_o),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  swd_req_enc u_enc (
    .apndp_i (cmd_apndp_i),
    .rnw_i   (cmd_rnw_i),
    .addr_i  (cmd_addr_i),
    .pkt_o   (pkt)
  );

  swd_rx u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (accept),
    .samp_ack_i (rise && (phase_q == PH_ACK)),
    .samp_dat_i (rise && (phase_q == PH_RDATA)),
    .din_i      (swdio_i),
    .ack_o      (rx_ack),
    .data_o     (rx_data),
    .par_bad_o  (par_bad)
  );

  assign ack_ok = (rx_ack == ACK_OK);

  always_comb begin
    case (phase_q)
      PH_REQ:                 last_bit = CW'(7);
      PH_ACK:                 last_bit = CW'(2);
      PH_RDATA, PH_WDATA:     last_bit = CW'(WORD_W);
      PH_SEQ:                 last_bit = CW'(15);
      PH_LRST, PH_LRST2:      last_bit = CW'(LRST_CYCLES - 1);
      default:                last_bit = '0;
    endcase
  end

  assign slot_end = fall && (bit_q == last_bit);

  always_comb begin
    case (phase_q)
      PH_REQ:   nxt_phase = PH_TRN1;
      PH_TRN1:  nxt_phase = PH_ACK;
      PH_ACK:   nxt_phase = !ack_ok ? PH_TRN2 : (rnw_q ? PH_RDATA : PH_WTRN);
      PH_RDATA: nxt_phase = PH_TRN2;
      PH_WTRN:  nxt_phase = PH_WDATA;
      PH_LRST:  nxt_phase = (op_q == OP_J2S) ? PH_SEQ : PH_IDLE;
      PH_SEQ:   nxt_phase = PH_LRST2;
      default:  nxt_phase = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH_IDLE;
      op_q        <= OP_XFER;
      bit_q       <= '0;
      pkt_q       <= '0;
      wdata_q     <= '0;
      wpar_q      <= 1'b0;
      rnw_q       <= 1'b0;
      rd_ok_q     <= 1'b0;
      rsp_valid_q <= 1'b0;
    end else begin
      rsp_valid_q <= slot_end && ((phase_q == PH_TRN2) || (phase_q == PH_WDATA));
      if (accept) begin
        op_q    <= swd_op_e'(cmd_op_i);
        phase_q <= (swd_op_e'(cmd_op_i) == OP_XFER) ? PH_REQ : PH_LRST;
        bit_q   <= '0;
        pkt_q   <= pkt;
        wdata_q <= cmd_wdata_i;
        wpar_q  <= even_par(cmd_wdata_i);
        rnw_q   <= cmd_rnw_i;
        rd_ok_q <= 1'b0;
      end else if (fall) begin
        if (bit_q == last_bit) begin
          bit_q   <= '0;
          phase_q <= nxt_phase;
          if (phase_q == PH_RDATA) rd_ok_q <= 1'b1;
        end else begin
          bit_q <= bit_q + CW'(1);
        end
      end
    end
  end

  // line driver, updated only in the cycle the clock falls
  always_comb begin
    sdo = 1'b0;
    soe = 1'b0;
    case (phase_q)
      PH_IDLE:  soe = 1'b1;
      PH_REQ:   begin soe = 1'b1; sdo = pkt_q[bit_q[2:0]]; end
      PH_WDATA: begin
        soe = 1'b1;
        sdo = (bit_q == CW'(WORD_W)) ? wpar_q : wdata_q[bit_q[4:0]];
      end
      PH_LRST, PH_LRST2: begin soe = 1'b1; sdo = 1'b1; end
      PH_SEQ:   begin soe = 1'b1; sdo = SWITCH_WORD[bit_q[3:0]]; end
      default:  ;
    endcase
  end

  assign swdio_o     = sdo;
  assign swdio_oe_o  = soe;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_ack_o   = rx_ack;
  assign rsp_rdata_o = rd_ok_q ? rx_data : '0;
  assign rsp_perr_o  = rd_ok_q && par_bad;

  assert_idle_clk_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> !swclk_o);

  assert_drive_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swclk_o && $past(swclk_o)) |-> ($stable(swdio_o) && $stable(swdio_oe_o)));

  assert_rsp_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  assert_perr_needs_ok_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_perr_o) |-> (rsp_ack_o == ACK_OK));

  assert_data_after_ok_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((phase_q == PH_RDATA) || (phase_q == PH_WDATA)) |-> (rsp_ack_o == ACK_OK));
endmodule

// File: tb/swd_host_bench.sv
`timescale 1ns/1ps
module swd_host_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  clk_div = 8'd1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready_o;
  logic [1:0]  cmd_op = 2'd0;
  logic        cmd_apndp = 1'b0, cmd_rnw = 1'b0;
  logic [1:0]  cmd_addr = 2'd0;
  logic [31:0] cmd_wdata = '0;
  logic        rsp_valid_o, rsp_perr_o;
  logic [2:0]  rsp_ack_o;
  logic [31:0] rsp_rdata_o;
  logic        swclk_o, swdio_o, swdio_oe_o;
  logic        swdio_i = 1'b1;

  always #10 clk = ~clk;

  swd_host #(.DIV_W(8), .LRST_CYCLES(50)) u_swd_host (
    .clk_i(clk), .rst_ni(rst_n), .clk_div_i(clk_div),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready_o), .cmd_op_i(cmd_op),
    .cmd_apndp_i(cmd_apndp), .cmd_rnw_i(cmd_rnw), .cmd_addr_i(cmd_addr),
    .cmd_wdata_i(cmd_wdata), .rsp_valid_o(rsp_valid_o), .rsp_ack_o(rsp_ack_o),
    .rsp_rdata_o(rsp_rdata_o), .rsp_perr_o(rsp_perr_o), .swclk_o(swclk_o),
    .swdio_o(swdio_o), .swdio_oe_o(swdio_oe_o), .swdio_i(swdio_i)
  );

  typedef struct {
    logic [2:0]  ack;
    logic [31:0] rdata;
    logic        perr;
    string       tag;
  } exp_t;

  exp_t    expq[$];
  int      checks = 0, errors = 0;
  int      rcnt = 0, fcnt = 0, r9_bad = 0;
  logic    log_d  [256];
  logic    log_oe [256];
  realtime log_t  [256];
  logic    tgt_bits [256];
  logic [7:0] last_req;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // wire log at each rising debug clock
  always @(posedge swclk_o) begin
    #1;
    if (rcnt < 256) begin
      log_d[rcnt]  = swdio_o;
      log_oe[rcnt] = swdio_oe_o;
      log_t[rcnt]  = $realtime;
    end
    rcnt++;
  end

  // target model: drives its slot value after each falling edge
  always @(negedge swclk_o) begin
    #1;
    fcnt++;
    swdio_i = (fcnt < 256) ? tgt_bits[fcnt] : 1'b1;
  end

  // R9 watcher: any change of the drive must settle with the clock low
  always @(swdio_o or swdio_oe_o) begin
    #1;
    if (rst_n && swclk_o) r9_bad++;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    exp_t e;
    if (rst_n && rsp_valid_o) begin
      if (expq.size() == 0) chk(1'b0, "R11", "response without transfer", 1, 0);
      else begin
        e = expq.pop_front();
        chk(rsp_ack_o == e.ack, e.tag, "ack", rsp_ack_o, e.ack);
        chk(rsp_rdata_o == e.rdata, e.tag, "rdata", rsp_rdata_o, e.rdata);
        chk(rsp_perr_o == e.perr, e.tag, "parity error", rsp_perr_o, e.perr);
      end
    end
  end

  task automatic issue(input logic [1:0] op, input logic ap, input logic rnw,
                       input logic [1:0] addr, input logic [31:0] wd);
    while (!cmd_ready_o) @(negedge clk);
    rcnt = 0;
    fcnt = 0;
    cmd_op = op; cmd_apndp = ap; cmd_rnw = rnw; cmd_addr = addr; cmd_wdata = wd;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!cmd_ready_o, "R11", "ready while busy", cmd_ready_o, 0);
    while (!cmd_ready_o) @(negedge clk);
    chk(!swclk_o && swdio_oe_o && !swdio_o, "R10", "idle wire state",
        {swclk_o, swdio_oe_o, swdio_o}, 3'b010);
  endtask

  task automatic xfer(input logic ap, input logic rnw, input logic [1:0] addr,
                      input logic [31:0] wd, input logic [2:0] ack,
                      input logic [31:0] td, input bit badp, input string tag);
    bit ok = (ack == 3'b001);
    logic [7:0] ereq;
    exp_t e;
    int n;
    bit good;
    for (int i = 0; i < 256; i++) tgt_bits[i] = 1'b1;
    for (int i = 0; i < 3; i++) tgt_bits[9+i] = ack[i];
    if (ok && rnw) begin
      for (int i = 0; i < 32; i++) tgt_bits[12+i] = td[i];
      tgt_bits[44] = (^td) ^ badp;
    end
    ereq = {1'b1, ap, rnw, addr[0], addr[1], ap ^ rnw ^ addr[0] ^ addr[1], 1'b0, 1'b1};
    e.ack = ack;
    e.rdata = (ok && rnw) ? td : 32'h0;
    e.perr = ok && rnw && badp;
    e.tag = tag;
    expq.push_back(e);
    issue(2'd0, ap, rnw, addr, wd);
    n = ok ? 46 : 13;
    chk(rcnt == n, ok ? "R3" : "R6", "slot count", rcnt, n);
    last_req = {log_d[0], log_d[1], log_d[2], log_d[3], log_d[4], log_d[5], log_d[6], log_d[7]};
    chk(last_req == ereq, "R1", "request bits", last_req, ereq);
    good = 1;
    for (int i = 0; i < 8; i++) if (!log_oe[i]) good = 0;
    chk(good, "R1", "request driven", 0, 1);
    good = 1;
    for (int i = 8; i < 13; i++) if (log_oe[i]) good = 0;
    chk(good, "R2", "turnaround and ack released", 1, 0);
    if (ok && rnw) begin
      good = 1;
      for (int i = 13; i < 46; i++) if (log_oe[i]) good = 0;
      chk(good, "R3", "read phase and final turnaround released", 1, 0);
    end
    if (ok && !rnw) begin
      good = 1;
      for (int i = 13; i < 46; i++) if (!log_oe[i]) good = 0;
      chk(good, "R5", "write phase driven", 0, 1);
      for (int i = 0; i < 32; i++) if (log_d[13+i] != wd[i]) good = 0;
      chk(good, "R5", "write bits LSB first", 0, wd);
      chk(log_d[45] == ^wd, "R5", "write parity", log_d[45], ^wd);
    end
  endtask

  task automatic line_cmd(input logic [1:0] op);
    int n;
    bit good;
    logic [15:0] sw;
    for (int i = 0; i < 256; i++) tgt_bits[i] = 1'b1;
    issue(op, 1'b0, 1'b0, 2'd0, 32'h0);
    n = (op == 2'd2) ? 116 : 50;
    chk(rcnt == n, (op == 2'd2) ? "R8" : "R7", "slot count", rcnt, n);
    good = 1;
    for (int i = 0; i < n; i++) if (!log_oe[i]) good = 0;
    for (int i = 0; i < 50; i++) if (!log_d[i]) good = 0;
    chk(good, "R7", "leading reset high", 0, 1);
    if (op == 2'd2) begin
      for (int i = 0; i < 16; i++) sw[i] = log_d[50+i];
      chk(sw == 16'hE79E, "R8", "switch word", sw, 16'hE79E);
      good = 1;
      for (int i = 66; i < 116; i++) if (!log_d[i]) good = 0;
      chk(good, "R8", "trailing reset high", 0, 1);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) tgt_bits[i] = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready_o, "R11", "ready after reset", cmd_ready_o, 1);
    chk(!rsp_valid_o, "R11", "no response after reset", rsp_valid_o, 0);
    chk(!swclk_o, "R10", "clock low after reset", swclk_o, 0);
    chk(swdio_oe_o && !swdio_o, "R9", "idle drive low", {swdio_oe_o, swdio_o}, 2'b10);

    line_cmd(2'd2);
    chk(int'(log_t[1] - log_t[0]) == 80, "R10", "period div 1", int'(log_t[1] - log_t[0]), 80);
    line_cmd(2'd1);

    xfer(1'b0, 1'b1, 2'd0, 32'h0, 3'b001, 32'h2BA01477, 1'b0, "R3");
    chk(last_req == 8'b10100101, "R1", "DP read addr 0 encoding", last_req, 8'b10100101);
    xfer(1'b0, 1'b0, 2'd1, 32'h50000000, 3'b001, 32'h0, 1'b0, "R5");
    chk(last_req == 8'b10010101, "R1", "DP write addr 4 encoding", last_req, 8'b10010101);
    xfer(1'b0, 1'b1, 2'd1, 32'h0, 3'b001, 32'hF0000040, 1'b1, "R4");
    chk(last_req == 8'b10110001, "R1", "DP read addr 4 encoding", last_req, 8'b10110001);
    xfer(1'b0, 1'b1, 2'd1, 32'h0, 3'b001, 32'hFFFFFFFF, 1'b1, "R4");
    xfer(1'b1, 1'b1, 2'd3, 32'h0, 3'b010, 32'h12345678, 1'b0, "R6");
    xfer(1'b1, 1'b0, 2'd2, 32'hDEADBEEF, 3'b100, 32'h0, 1'b0, "R6");
    xfer(1'b1, 1'b1, 2'd0, 32'h0, 3'b111, 32'hAAAA5555, 1'b0, "R6");
    xfer(1'b1, 1'b0, 2'd3, 32'h00000001, 3'b001, 32'h0, 1'b0, "R5");
    xfer(1'b1, 1'b1, 2'd2, 32'h0, 3'b001, 32'h80000001, 1'b0, "R3");

    @(negedge clk);
    @(negedge clk);
    clk_div = 8'd3;
    xfer(1'b0, 1'b1, 2'd3, 32'h0, 3'b001, 32'h0000FFFF, 1'b0, "R3");
    chk(int'(log_t[1] - log_t[0]) == 160, "R10", "period div 3", int'(log_t[1] - log_t[0]), 160);
    line_cmd(2'd3);

    repeat (4) @(negedge clk);
    chk(expq.size() == 0, "R11", "responses outstanding", expq.size(), 0);
    chk(r9_bad == 0, "R9", "drive changes while clock high", r9_bad, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    chk(1'b0, "R11", "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule